// File: doc/BRIEF.md
# Interrupt Request Aggregator with Edge/Level Output

This block gathers fourteen independent event sources into latched request bits and folds them into one interrupt pin. Every source raises its own request flag with a single-cycle pulse. A processor reaches the flags through a small register bus: it reads the flags, clears them by writing ones, masks each one with a per-source enable bit, and gates the whole pin with a global enable bit.

The pin works in one of two ways, chosen by two configuration inputs. In level mode it behaves as an active-low open-drain output: it pulls low while any enabled request is pending. In edge mode it is a push-pull output whose idle level is chosen by the polarity input. Because an edge-triggered receiver only sees transitions, the block forces the pin back to its inactive level for a fixed number of clock cycles whenever a new event arrives while the pin is already active. That gives the receiver a fresh edge for every pending event.

Register map (word address on `bus_addr`): 0 = request flags (bit i is source i, write-one-to-clear); 1 = per-source enables (bit i is source i, plain read/write); 2 = control, where bit 0 is the global enable and all other bits read as 0; 3 = unused, reads 0 and ignores writes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the request register reads 0x0019 (sources 0, 3 and 4 start pending, all others clear), the enable register reads 0 and the control register reads 0.
- R2: A read of address 0 returns the latched request flags whatever the enable bits hold.
- R3: Writing address 0 clears every request bit written as 1. Bits written as 0 keep their value.
- R4: If a source pulse and a write-one-clear hit the same bit in the same cycle, the bit ends up set.
- R5: The internal pending condition is the OR over all sources of (request AND enable), gated by the global enable. While the global enable is 0, the pin is inactive: released (`int_oe`=0) in level mode, driven to its idle level in edge mode.
- R6: In level mode (`cfg_level`=1), `int_o` is 0, and `int_oe` is 1 exactly while the pending condition holds. The pin is released only once the last enabled request is cleared.
- R7: In edge mode (`cfg_level`=0), `int_oe` is 1. With `cfg_pos`=0 the pin idles high and is active low; with `cfg_pos`=1 it idles low and is active high.
- R8: In edge mode, if an enabled request bit newly sets while the pin is active, and the pending condition still holds afterwards, the pin goes inactive for exactly PULSE_CYC cycles starting in the cycle after the set is latched. It then returns to active.
- R9: In edge mode, a processor clear of an enabled pending request that leaves another enabled request pending produces the same PULSE_CYC-cycle inactive pulse. A clear of the last one returns the pin to idle with no pulse.
- R10: Writing an enable bit for a request that is already pending, with the global enable set, makes the pin active in the cycle after the write.
- R11: Address 3 reads 0. Bits 13:1 of the control register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | NUM_SRC | One-cycle set pulse per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | NUM_SRC | Register write data |
| bus_rdata | output | NUM_SRC | Register read data (combinational from bus_addr) |
| cfg_level | input | 1 | 1 = open-drain level mode, 0 = push-pull edge mode |
| cfg_pos | input | 1 | Edge mode polarity: 1 = active high, 0 = active low |
| int_o | output | 1 | Pin drive value |
| int_oe | output | 1 | Pin output enable (open-drain release when 0) |

## Verification
The bench targets the cycle in which a set and a clear collide on one bit; a design where the clear wins would silently lose that event. It measures the inactive pulse edge to edge, on a new request and on a clear that leaves others pending. An off-by-one counter would show a short or long pulse, and a missing retrigger would leave the pin flat. It also enables an already-pending source and toggles the global enable, mode and polarity. A design that only reacted to fresh sets, or ignored the gate in one mode, would leave the pin idle or drive it wrongly.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam logic [1:0] ADDR_REQ = 2'd0;
  localparam logic [1:0] ADDR_EN  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  // Pin mapping: returns {drive value, output enable}
  function automatic logic [1:0] pin_drive(input logic level_mode,
                                           input logic pos_pol,
                                           input logic active);
    logic [1:0] r;
    if (level_mode) r = {1'b0, active};
    else            r = {(active ? pos_pol : ~pos_pol), 1'b1};
    return r;
  endfunction

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned NUM_SRC = 14,
  parameter logic [NUM_SRC-1:0] RST_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic [NUM_SRC-1:0] rise_o,
  output logic [NUM_SRC-1:0] drop_o
);

  logic [NUM_SRC-1:0] req_q;

  // Clear first, then set: a colliding set wins
  function automatic logic [NUM_SRC-1:0] next_req(input logic [NUM_SRC-1:0] cur,
                                                  input logic [NUM_SRC-1:0] clr,
                                                  input logic [NUM_SRC-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= RST_MASK;
    else        req_q <= next_req(req_q, clr_i, set_i);
  end

  assign req_o  = req_q;
  assign rise_o = set_i & ~req_q;
  assign drop_o = clr_i & req_q & ~set_i;

  assert_set_wins_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((req_q & $past(set_i)) == $past(set_i)));

  assert_w1c_clears_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((req_q & $past(clr_i & ~set_i)) == '0));

  assert_zero_keeps_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (~(clr_i | set_i) != '0) |=>
      ((req_q & ~$past(clr_i | set_i)) == ($past(req_q) & ~$past(clr_i | set_i))));

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic evt_i,
  input  logic level_i,
  input  logic pos_i,
  output logic int_o,
  output logic int_oe,
  output logic active_o,
  output logic pulse_o
);

  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic          evt_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          pulse_start;

  // Retrigger when the pin was active, an event was latched, and it stays pending
  assign pulse_start = pend_i && pend_q && evt_q;
  assign pulse_o     = pulse_start || (cnt_q != '0);
  assign active_o    = level_i ? pend_i : (pend_i && !pulse_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      evt_q  <= evt_i;
      pend_q <= pend_i;
      if (pulse_start)        cnt_q <= CW'(PULSE_CYC - 1);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign {int_o, int_oe} = pin_drive(level_i, pos_i, active_o);

  assert_retrigger_inactive_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && pend_q && pend_i && !level_i) |-> (int_oe && (int_o == !pos_i)));

  assert_level_drive_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    level_i |-> (!int_o && (int_oe == pend_i)));

  assert_edge_oe_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !level_i |-> int_oe);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 14,
  parameter int unsigned PULSE_CYC = 128,
  parameter logic [NUM_SRC-1:0] RST_MASK = NUM_SRC'(14'h0019)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  input  logic               cfg_level,
  input  logic               cfg_pos,
  output logic               int_o,
  output logic               int_oe
);

  logic [NUM_SRC-1:0] en_q;
  logic               gie_q;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] drop;
  logic [NUM_SRC-1:0] clr_mask;
  logic               pend;
  logic               evt;
  logic               pin_active;
  logic               pin_pulse;

  assign clr_mask = (bus_wr && bus_addr == ADDR_REQ) ? bus_wdata : '0;

  irq_req_bank #(.NUM_SRC(NUM_SRC), .RST_MASK(RST_MASK)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (src_set),
    .clr_i  (clr_mask),
    .req_o  (req),
    .rise_o (rise),
    .drop_o (drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_EN)  en_q  <= bus_wdata;
      if (bus_addr == ADDR_CTL) gie_q <= bus_wdata[0];
    end
  end

  assign pend = gie_q && (|(req & en_q));
  assign evt  = gie_q && (|((rise | drop) & en_q));

  always_comb begin
    case (bus_addr)
      ADDR_REQ: bus_rdata = req;
      ADDR_EN:  bus_rdata = en_q;
      ADDR_CTL: bus_rdata = NUM_SRC'(gie_q);
      default:  bus_rdata = '0;
    endcase
  end

  irq_pin_ctrl #(.PULSE_CYC(PULSE_CYC)) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend),
    .evt_i    (evt),
    .level_i  (cfg_level),
    .pos_i    (cfg_pos),
    .int_o    (int_o),
    .int_oe   (int_oe),
    .active_o (pin_active),
    .pulse_o  (pin_pulse)
  );

  assert_gie_off_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> (cfg_level ? !int_oe : (int_oe && int_o == !cfg_pos)));

  assert_enable_pending_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_EN && gie_q && (|(bus_wdata & req))) |=>
      (!cfg_level || int_oe));

  assert_pulse_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pulse && !cfg_level) |-> !pin_active);

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

  localparam int N = 14;
  localparam int P = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_set = '0;
  logic         bus_wr = 1'b0;
  logic [1:0]   bus_addr = 2'd0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         cfg_level = 1'b0;
  logic         cfg_pos = 1'b0;
  logic         int_o;
  logic         int_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model state
  logic [N-1:0] m_req;
  logic [N-1:0] m_en;
  logic         m_gie;
  int           m_rem;

  always #4 clk = ~clk;

  irq_aggregator #(.NUM_SRC(N), .PULSE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_level(cfg_level), .cfg_pos(cfg_pos), .int_o(int_o), .int_oe(int_oe)
  );

  // Per-bit request update: a source pulse always leaves its bit set
  function automatic logic [N-1:0] f_req(input logic [N-1:0] cur, input logic [N-1:0] set,
                                         input logic wr, input logic [1:0] a,
                                         input logic [N-1:0] d);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (set[i])                         r[i] = 1'b1;
      else if (wr && a == 2'd0 && d[i])   r[i] = 1'b0;
      else                                r[i] = cur[i];
    end
    return r;
  endfunction

  // Expected {int_o, int_oe}
  function automatic logic [1:0] f_pin(input logic lvl, input logic pos, input logic act);
    logic o, oe;
    oe = lvl ? act : 1'b1;
    o  = lvl ? 1'b0 : ~(act ^ pos);
    return {o, oe};
  endfunction

  function automatic logic f_pend(input logic [N-1:0] r, input logic [N-1:0] e, input logic g);
    return g && ((r & e) != '0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model update at each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 14'h0019; m_en = '0; m_gie = 1'b0; m_rem = 0;
    end else begin
      logic old_p, new_p, ev;
      logic [N-1:0] newly, gone;
      old_p = f_pend(m_req, m_en, m_gie);
      newly = src_set & ~m_req;
      gone  = (bus_wr && bus_addr == 2'd0) ? (bus_wdata & m_req & ~src_set) : '0;
      ev    = m_gie && (((newly | gone) & m_en) != '0);
      m_req = f_req(m_req, src_set, bus_wr, bus_addr, bus_wdata);
      if (bus_wr && bus_addr == 2'd1) m_en  = bus_wdata;
      if (bus_wr && bus_addr == 2'd2) m_gie = bus_wdata[0];
      new_p = f_pend(m_req, m_en, m_gie);
      if (m_rem > 0) m_rem--;
      if (ev && old_p && new_p) m_rem = P;
    end
  end

  // Continuous pin comparison away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic act;
      string tg;
      act = f_pend(m_req, m_en, m_gie) && (cfg_level || m_rem == 0);
      if (!m_gie)          tg = "R5";
      else if (cfg_level)  tg = "R6";
      else if (m_rem > 0)  tg = "R8";
      else                 tg = "R7";
      check({tg, " pin"}, {30'd0, int_o, int_oe}, {30'd0, f_pin(cfg_level, cfg_pos, act)});
    end
  end

  task automatic step(input logic w, input logic [1:0] a, input logic [N-1:0] d,
                      input logic [N-1:0] s);
    @(posedge clk); #2;
    bus_wr = w; bus_addr = a; bus_wdata = d; src_set = s;
  endtask

  task automatic idle_to_neg();
    step(1'b0, 2'd0, '0, '0);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
    step(1'b0, a, '0, '0);
    @(negedge clk);
    check(tag, {18'd0, bus_rdata}, {18'd0, exp});
  endtask

  task automatic pin_is(input logic o, input logic oe, input string tag);
    check(tag, {30'd0, int_o, int_oe}, {30'd0, o, oe});
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 14'h0019, "R1 req");
    rd(2'd1, 14'h0000, "R1 en");
    rd(2'd2, 14'h0000, "R1 ctl");
    pin_is(1'b1, 1'b1, "R5 idle edge neg");

    // Global enable, no source enable: stays idle
    step(1'b1, 2'd2, 14'h0001, '0);
    idle_to_neg();
    pin_is(1'b1, 1'b1, "R5 gie only");
    // R10: enable an already-pending source
    step(1'b1, 2'd1, 14'h0001, '0);
    idle_to_neg();
    pin_is(1'b0, 1'b1, "R10 enable pending");
    rd(2'd0, 14'h0019, "R2 req with enable");
    rd(2'd2, 14'h0001, "R11 ctl bits");
    rd(2'd3, 14'h0000, "R11 unused addr");

    // R3 clear by ones, last one cleared -> idle
    step(1'b1, 2'd0, 14'h0019, '0);
    idle_to_neg();
    pin_is(1'b1, 1'b1, "R9 last clear idle");
    rd(2'd0, 14'h0000, "R3 w1c");
    step(1'b0, 2'd0, '0, 14'h0002);
    step(1'b1, 2'd0, 14'h0000, '0);
    rd(2'd0, 14'h0002, "R3 write zero keeps");
    // R4 collision on bit 2
    step(1'b1, 2'd0, 14'h0004, 14'h0004);
    rd(2'd0, 14'h0006, "R4 set wins");

    // R8 retrigger on a new request while active
    step(1'b1, 2'd1, 14'h0026, '0);
    idle_to_neg();
    pin_is(1'b0, 1'b1, "R7 active low");
    step(1'b0, 2'd0, '0, 14'h0020);
    idle_to_neg();
    pin_is(1'b1, 1'b1, "R8 pulse start");
    repeat (P - 1) @(negedge clk);
    pin_is(1'b1, 1'b1, "R8 pulse last");
    @(negedge clk);
    pin_is(1'b0, 1'b1, "R8 pulse end");

    // R9 clear one of several
    step(1'b1, 2'd0, 14'h0002, '0);
    idle_to_neg();
    pin_is(1'b1, 1'b1, "R9 pulse start");
    repeat (P) @(negedge clk);
    pin_is(1'b0, 1'b1, "R9 pulse end");

    // R7 positive polarity
    cfg_pos = 1'b1;
    @(negedge clk);
    pin_is(1'b1, 1'b1, "R7 active high");
    // R6 level mode
    cfg_level = 1'b1;
    @(negedge clk);
    pin_is(1'b0, 1'b1, "R6 level pull");
    step(1'b1, 2'd0, 14'h0004, '0);
    idle_to_neg();
    pin_is(1'b0, 1'b1, "R6 still pending");
    // R5 global off in level mode
    step(1'b1, 2'd2, 14'h0000, '0);
    idle_to_neg();
    pin_is(1'b0, 1'b0, "R5 level released");
    step(1'b1, 2'd2, 14'h0001, '0);
    step(1'b1, 2'd0, 14'h0020, '0);
    idle_to_neg();
    pin_is(1'b0, 1'b0, "R6 last clear release");
    cfg_level = 1'b0;
    @(negedge clk);
    pin_is(1'b0, 1'b1, "R7 idle low");

    // Constrained random phase, checked by the continuous model compare
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] s;
      int r;
      s = (($urandom % 6) == 0) ? N'(1) << ($urandom % N) : '0;
      r = $urandom % 10;
      if (r == 0)      step(1'b1, 2'd1, N'($urandom), s);
      else if (r == 1) step(1'b1, 2'd0, N'(1) << ($urandom % N), s);
      else if (r == 2) step(1'b1, 2'd2, {13'd0, (($urandom % 5) != 0)}, s);
      else begin
        logic [1:0] a;
        a = 2'($urandom % 4);
        step(1'b0, a, '0, s);
        @(negedge clk);
        case (a)
          2'd0: check("R2 rand req", {18'd0, bus_rdata}, {18'd0, m_req});
          2'd1: check("R2 rand en",  {18'd0, bus_rdata}, {18'd0, m_en});
          2'd2: check("R11 rand ctl", {18'd0, bus_rdata}, {31'd0, m_gie});
          default: check("R11 rand unused", {18'd0, bus_rdata}, 32'd0);
        endcase
      end
      if (($urandom % 200) == 0) cfg_level = ~cfg_level;
      if (($urandom % 250) == 0) cfg_pos = ~cfg_pos;
    end
    step(1'b0, 2'd0, '0, '0);
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule